// File: doc/BRIEF.md
# Address-Space Tagged Translation Buffer

A fully associative buffer of virtual-to-physical page translations for an 8 KB page system. Every slot holds a virtual page tag, an address-space number and a global flag, and beside them a physical page number, per-mode read and write enable masks, and fault-on-read and fault-on-write flags. A lookup port takes a virtual page number and the current address-space number. In the same cycle it returns a hit flag and the fields of the matching slot.

Fills go to the slot chosen by a next-to-use pointer, which moves round the table in a ring. Three invalidation commands are available. One drops every slot. One drops only the slots that are not global. One drops the slots that match a single page for one address space. A separate port shows the slot under the pointer and can move the pointer forward without writing anything. Page-table walking, permission checking and statistics belong to the surrounding logic.

Top module: `asn_tlb`

## Requirements
- R1: After reset every slot is invalid, the pointer is 0, and every lookup misses.
- R2: A slot matches a request when it is valid, its tag equals the requested page, and either its global flag is 1 or its stored address-space number equals the requested one. `lk_hit` is combinational.
- R3: When several slots match, the slot with the lowest index supplies the outputs. On a miss every lookup field output is 0.
- R4: An insert writes the slot under the pointer, replacing whatever it held, and marks it valid. A lookup then returns the stored physical page, masks, fault flags and global flag.
- R5: The pointer advances by one, wrapping from ENTRIES-1 to 0, on each cycle with an insert or an advance request or both. It advances only once even when both are asserted.
- R6: A flush-all invalidates every slot and resets the pointer to 0.
- R7: A flush-process invalidates every slot whose global flag is 0 and leaves global slots valid.
- R8: A flush-page invalidates every slot that would match the given page and address-space number under the rule of R2.
- R9: The index port shows the pointer, the valid bit of the slot under it, and that slot's tag, address-space number, physical page and global flag. Moving the pointer with the advance request writes no slot.
- R10: When a flush and an insert arrive in the same cycle, the flush is applied first. The new entry survives and lands at slot 0 if the flush was a flush-all.
- R11: The read and write enable masks have one bit per privilege mode: bit 0 is kernel, bit 1 executive, bit 2 supervisor and bit 3 user. They are stored and returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | VPN_W | Lookup virtual page |
| lk_asn | input | ASN_W | Lookup address-space number |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Physical page of the hit |
| lk_rd_en | output | MODES | Read enable per mode |
| lk_wr_en | output | MODES | Write enable per mode |
| lk_f_rd | output | 1 | Fault-on-read flag |
| lk_f_wr | output | 1 | Fault-on-write flag |
| lk_glob | output | 1 | Global flag of the hit |
| ins_valid | input | 1 | Insert strobe |
| ins_vpn | input | VPN_W | Tag to insert |
| ins_asn | input | ASN_W | Address-space number to insert |
| ins_glob | input | 1 | Global flag to insert |
| ins_ppn | input | PPN_W | Physical page to insert |
| ins_rd_en | input | MODES | Read enables to insert |
| ins_wr_en | input | MODES | Write enables to insert |
| ins_f_rd | input | 1 | Fault-on-read to insert |
| ins_f_wr | input | 1 | Fault-on-write to insert |
| fl_all | input | 1 | Invalidate every slot |
| fl_proc | input | 1 | Invalidate non-global slots |
| fl_page | input | 1 | Invalidate slots matching fl_vpn/fl_asn |
| fl_vpn | input | VPN_W | Page for fl_page |
| fl_asn | input | ASN_W | Address-space number for fl_page |
| vic_adv | input | 1 | Advance the pointer |
| vic_idx | output | IW | Current pointer |
| vic_valid | output | 1 | Valid bit of the slot under the pointer |
| vic_vpn | output | VPN_W | Tag of that slot |
| vic_asn | output | ASN_W | Address-space number of that slot |
| vic_glob | output | 1 | Global flag of that slot |
| vic_ppn | output | PPN_W | Physical page of that slot |

## Verification
Every cycle, the assertions check pointer motion, both its single-step wrap and its reset by flush-all. They also check that an inserted slot is valid on the following cycle, that no slot is valid after a flush-all, and that no non-global slot is valid after a flush-process. Several behaviours need the bench's scenarios and its reference model. These are the match rule across address spaces and the global flag, the lowest-index choice among duplicate tags, the selective effect of flush-page, and the stored field values.

// File: rtl/asn_tlb.sv
module asn_tlb #(
  parameter int ENTRIES = 48,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ASN_W   = 8,
  parameter int MODES   = 4,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [ASN_W-1:0] lk_asn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output logic [MODES-1:0] lk_rd_en,
  output logic [MODES-1:0] lk_wr_en,
  output logic             lk_f_rd,
  output logic             lk_f_wr,
  output logic             lk_glob,
  input  logic             ins_valid,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [ASN_W-1:0] ins_asn,
  input  logic             ins_glob,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic [MODES-1:0] ins_rd_en,
  input  logic [MODES-1:0] ins_wr_en,
  input  logic             ins_f_rd,
  input  logic             ins_f_wr,
  input  logic             fl_all,
  input  logic             fl_proc,
  input  logic             fl_page,
  input  logic [VPN_W-1:0] fl_vpn,
  input  logic [ASN_W-1:0] fl_asn,
  input  logic             vic_adv,
  output logic [IW-1:0]    vic_idx,
  output logic             vic_valid,
  output logic [VPN_W-1:0] vic_vpn,
  output logic [ASN_W-1:0] vic_asn,
  output logic             vic_glob,
  output logic [PPN_W-1:0] vic_ppn
);
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [ASN_W-1:0] asn;
    logic             glob;
    logic [PPN_W-1:0] ppn;
    logic [MODES-1:0] rd_en;
    logic [MODES-1:0] wr_en;
    logic             f_rd;
    logic             f_wr;
  } ent_t;

  ent_t               tbl [ENTRIES];
  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] kill;
  logic [IW-1:0]      ptr, base, ptr_nxt;
  logic [IW-1:0]      sel;
  ent_t               hit_ent;

  always_comb begin
    lk_hit = 1'b0;
    sel    = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vld[i] && tbl[i].vpn == lk_vpn && (tbl[i].glob || tbl[i].asn == lk_asn)) begin
        lk_hit = 1'b1;
        sel    = IW'(i);
      end
    end
  end

  assign hit_ent  = lk_hit ? tbl[sel] : '0;
  assign lk_ppn   = hit_ent.ppn;
  assign lk_rd_en = hit_ent.rd_en;
  assign lk_wr_en = hit_ent.wr_en;
  assign lk_f_rd  = hit_ent.f_rd;
  assign lk_f_wr  = hit_ent.f_wr;
  assign lk_glob  = hit_ent.glob;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      kill[i] = fl_all || (fl_proc && !tbl[i].glob) ||
                (fl_page && tbl[i].vpn == fl_vpn && (tbl[i].glob || tbl[i].asn == fl_asn));
  end

  assign base    = fl_all ? '0 : ptr;
  assign ptr_nxt = (ins_valid || vic_adv) ? ((base == LAST) ? '0 : base + 1'b1) : base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      ptr <= '0;
    end else begin
      vld <= vld & ~kill;
      if (ins_valid) vld[base] <= 1'b1;
      ptr <= ptr_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && ins_valid)
      tbl[base] <= '{vpn: ins_vpn, asn: ins_asn, glob: ins_glob, ppn: ins_ppn,
                     rd_en: ins_rd_en, wr_en: ins_wr_en, f_rd: ins_f_rd, f_wr: ins_f_wr};
  end

  assign vic_idx   = ptr;
  assign vic_valid = vld[ptr];
  assign vic_vpn   = tbl[ptr].vpn;
  assign vic_asn   = tbl[ptr].asn;
  assign vic_glob  = tbl[ptr].glob;
  assign vic_ppn   = tbl[ptr].ppn;

  logic local_live;
  assign local_live = |(vld & ~{ENTRIES{1'b0}} & ~glob_vec());

  function automatic logic [ENTRIES-1:0] glob_vec();
    logic [ENTRIES-1:0] g;
    for (int i = 0; i < ENTRIES; i++) g[i] = tbl[i].glob;
    return g;
  endfunction

  assert_ptr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid || vic_adv) && !fl_all |=>
      ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));
  assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid && !vic_adv && !fl_all |=> $stable(ptr));
  assert_flush_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fl_all && !ins_valid |=> vld == '0 && ptr == '0);
  assert_insert_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !fl_all |=> vld[$past(ptr)]);
  assert_flush_then_insert_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && fl_all |=> vld[0] && $countones(vld) == 1);
  assert_flush_proc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fl_proc && !ins_valid |=> !local_live);
endmodule

// File: tb/asn_tlb_tb.sv
module asn_tlb_tb;
  localparam int N = 48, VW = 20, PW = 20, AW = 8, M = 4;
  localparam int IW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [VW-1:0] lk_vpn = '0, ins_vpn = '0, fl_vpn = '0, vic_vpn;
  logic [AW-1:0] lk_asn = '0, ins_asn = '0, fl_asn = '0, vic_asn;
  logic [PW-1:0] lk_ppn, ins_ppn = '0, vic_ppn;
  logic [M-1:0]  lk_rd_en, lk_wr_en, ins_rd_en = '0, ins_wr_en = '0;
  logic lk_hit, lk_f_rd, lk_f_wr, lk_glob, vic_valid, vic_glob;
  logic ins_valid = 0, ins_glob = 0, ins_f_rd = 0, ins_f_wr = 0;
  logic fl_all = 0, fl_proc = 0, fl_page = 0, vic_adv = 0;
  logic [IW-1:0] vic_idx;

  asn_tlb #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW), .ASN_W(AW), .MODES(M)) u_dut (.*);

  bit m_v[N]; int m_vpn[N], m_asn[N], m_ppn[N], m_rd[N], m_wr[N]; bit m_g[N], m_fr[N], m_fw[N];
  int m_ptr;
  int vectors = 0, fails = 0, cycles = 0;
  string phase = "R1 reset";

  function automatic bit mhit(int i, int vpn, int asn);
    return m_v[i] && m_vpn[i] == vpn && (m_g[i] || m_asn[i] == asn);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
      m_ptr = 0;
    end else begin
      for (int i = 0; i < N; i++)
        if (fl_all || (fl_proc && !m_g[i]) || (fl_page && mhit(i, int'(fl_vpn), int'(fl_asn)))) m_v[i] = 0;
      if (fl_all) m_ptr = 0;
      if (ins_valid) begin
        m_v[m_ptr] = 1; m_vpn[m_ptr] = int'(ins_vpn); m_asn[m_ptr] = int'(ins_asn);
        m_g[m_ptr] = ins_glob; m_ppn[m_ptr] = int'(ins_ppn); m_rd[m_ptr] = int'(ins_rd_en);
        m_wr[m_ptr] = int'(ins_wr_en); m_fr[m_ptr] = ins_f_rd; m_fw[m_ptr] = ins_f_wr;
      end
      if (ins_valid || vic_adv) m_ptr = (m_ptr + 1) % N;
    end
  end

  always @(negedge clk) begin
    logic [PW+2*M+3:0] act, exp;
    logic [IW+VW+AW+PW+1:0] vact, vexp;
    int s;
    cycles++;
    if (rst_n) begin
      s = -1;
      for (int i = N - 1; i >= 0; i--) if (mhit(i, int'(lk_vpn), int'(lk_asn))) s = i;
      act = {lk_hit, lk_ppn, lk_rd_en, lk_wr_en, lk_f_rd, lk_f_wr, lk_glob};
      if (s < 0) exp = '0;
      else exp = {1'b1, PW'(m_ppn[s]), M'(m_rd[s]), M'(m_wr[s]), m_fr[s], m_fw[s], m_g[s]};
      vectors++;
      if (act !== exp) begin
        fails++;
        $display("FAIL %s lookup: actual %h expected %h", phase, act, exp);
      end
      vact = {vic_idx, vic_valid, 1'b0, VW'(0), AW'(0), PW'(0)};
      vexp = {IW'(m_ptr), m_v[m_ptr], 1'b0, VW'(0), AW'(0), PW'(0)};
      if (m_v[m_ptr]) begin
        vact = {vic_idx, vic_valid, vic_glob, vic_vpn, vic_asn, vic_ppn};
        vexp = {IW'(m_ptr), 1'b1, m_g[m_ptr], VW'(m_vpn[m_ptr]), AW'(m_asn[m_ptr]), PW'(m_ppn[m_ptr])};
      end
      vectors++;
      if (vact !== vexp) begin
        fails++;
        $display("FAIL %s index port: actual %h expected %h", phase, vact, vexp);
      end
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic put(int vpn, int asn, bit g, int ppn);
    ins_valid = 1; ins_vpn = VW'(vpn); ins_asn = AW'(asn); ins_glob = g; ins_ppn = PW'(ppn);
    ins_rd_en = M'(ppn); ins_wr_en = M'(ppn >> 4); ins_f_rd = ppn[0]; ins_f_wr = ppn[1];
    tick(); ins_valid = 0;
  endtask

  task automatic probe(int vpn, int asn);
    lk_vpn = VW'(vpn); lk_asn = AW'(asn); tick();
  endtask

  initial begin
    tick(); tick();
    // R1: reset state is checked explicitly here, then by the model
    vectors++;
    if (lk_hit !== 1'b0 || vic_idx !== '0 || vic_valid !== 1'b0) begin
      fails++; $display("FAIL R1 reset: actual %b%0d%b expected 0 0 0", lk_hit, vic_idx, vic_valid);
    end
    rst_n = 1; tick(); probe(5, 0);

    phase = "R2 R4 R11 insert and match";
    put(16'h10, 1, 0, 20'h1a5); put(16'h11, 2, 0, 20'h2c3); put(16'h12, 9, 1, 20'h3f7);
    probe(16'h10, 1); probe(16'h10, 2); probe(16'h11, 2); probe(16'h11, 1);
    probe(16'h12, 9); probe(16'h12, 77); probe(16'h13, 1);

    phase = "R3 lowest index wins";
    put(16'h55, 3, 0, 20'h0aa); put(16'h55, 4, 1, 20'h0bb); put(16'h55, 3, 1, 20'h0cc);
    probe(16'h55, 3); probe(16'h55, 4); probe(16'h55, 8);

    phase = "R5 pointer wrap";
    for (int k = 0; k < N + 3; k++) put(16'h100 + k, k % 4, (k % 5) == 0, 20'h4000 + k * 7);
    probe(16'h100, 0); probe(16'h100 + N, N % 4); probe(16'h10, 1);

    phase = "R9 advance only";
    vic_adv = 1; tick(); tick(); tick(); vic_adv = 0; probe(16'h100 + 6, 2);
    vic_adv = 1; ins_valid = 0; tick(); vic_adv = 0;
    phase = "R5 insert with advance";
    vic_adv = 1; put(16'h77, 5, 0, 20'h777); vic_adv = 0; probe(16'h77, 5);

    phase = "R8 flush page";
    put(16'h88, 1, 0, 20'h881); put(16'h88, 2, 0, 20'h882); put(16'h99, 6, 1, 20'h991);
    fl_page = 1; fl_vpn = 16'h88; fl_asn = 1; tick(); fl_page = 0;
    probe(16'h88, 1); probe(16'h88, 2);
    fl_page = 1; fl_vpn = 16'h99; fl_asn = 3; tick(); fl_page = 0;
    probe(16'h99, 6);

    phase = "R7 flush process";
    fl_proc = 1; tick(); fl_proc = 0;
    for (int k = 0; k < N + 3; k += 5) probe(16'h100 + k, k % 4);
    probe(16'h88, 2); probe(16'h77, 5);
    for (int k = 0; k < N; k++) begin vic_adv = 1; tick(); end
    vic_adv = 0;

    phase = "R10 flush page with insert";
    put(16'h66, 1, 0, 20'h661);
    fl_page = 1; fl_vpn = 16'h66; fl_asn = 1; put(16'h66, 1, 0, 20'h662); fl_page = 0;
    probe(16'h66, 1);

    phase = "R6 flush all";
    fl_all = 1; tick(); fl_all = 0;
    probe(16'h66, 1); probe(16'h100, 0);

    phase = "R10 flush all with insert";
    put(16'h31, 1, 0, 20'h311); put(16'h32, 1, 0, 20'h321);
    fl_all = 1; put(16'h33, 2, 1, 20'h331); fl_all = 0;
    probe(16'h31, 1); probe(16'h33, 0);
    phase = "R10 flush process with insert";
    fl_proc = 1; put(16'h34, 2, 0, 20'h341); fl_proc = 0;
    probe(16'h34, 2); probe(16'h33, 7);

    tick();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule